// File: doc/BRIEF.md
# BCH Error Location Bit Corrector

This block repairs one 512-byte sector that sits in a byte-wide buffer, using the bit error locations that a BCH error-locator unit has already found. On a start pulse it captures the following inputs:

- up to eight locations and an error count;
- an uncorrectable flag from the locator;
- the stored parity bytes;
- a strength code that selects BCH4, BCH8 or BCH16.

The locator numbers its locations from the far end of the codeword, with the parity bits first. For each location the block therefore removes the parity span, then reverses the bit order to find the data byte. It flips the selected bit with a read followed by a write, one location at a time and in list order.

A sector whose stored parity bytes are all 0xFF is treated as erased and is left untouched. An uncorrectable job is aborted without any buffer access, and a status bit records the abort. When the job ends, a one-cycle done pulse is given and the number of flipped bits is shown on a count output.

A second, purely combinational path reverses the byte order of a syndrome before it is passed to the locator. The span it reverses depends on the strength.

Top module: `bch_bitfix`

## Requirements
- R1: After reset, busy, done, fail, mem_rd_en and mem_wr_en are 0 and flip_count is 0. The buffer is never accessed while busy is 0.
- R2: The strength code selects the parity nibble count N: 0 gives 13 (BCH4), 1 gives 26 (BCH8) and 2 gives 52 (BCH16). Any location below 4*N is a parity bit, and it is skipped without any buffer access.
- R3: For any other location L, let A = L - 4*N. The block toggles bit (A mod 8) of byte address (4095 - A) / 8.
- R4: A location whose adjusted value A is 4096 or more lies beyond the sector and is skipped without any buffer access.
- R5: If every checked parity byte equals 0xFF, the sector is treated as erased and no buffer access is made. The block checks 7 bytes for BCH4, 13 for BCH8 and 26 for BCH16, with byte k in parity_in bits [8k+7:8k]. Done then follows with flip_count 0.
- R6: If uncorrectable is 1 at start, no buffer access is made. Done is asserted in the next cycle with fail set to 1. Fail stays at 1 until the next accepted start, which clears it.
- R7: Locations are handled in list order, where location k is err_locs bits [13k+12:13k]. Each accepted location takes one read cycle (mem_rd_en) followed by one write cycle (mem_wr_en). The write goes to the same address, carries the one-cycle-later read data with exactly one bit inverted, and repeated locations toggle the bit again.
- R8: At most 8 locations are processed. An err_count above 8 is handled as 8, and an err_count of 0 ends the job with no buffer access.
- R9: Done is high for exactly one cycle after the last location. While done is high, flip_count equals the number of writes made in the job. A start that arrives while busy is 1 is ignored.
- R10: synd_out byte i equals synd_in byte (M-1-i) for i < M, where M is 8 for BCH4, 13 for BCH8 and 28 for BCH16. All higher bytes of synd_out are 0.
- R11: Strength code 3 behaves exactly like BCH8, in the location mapping, the erased check and the syndrome reversal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a job when idle |
| strength | input | 2 | Strength code: 0 BCH4, 1 BCH8, 2 BCH16, 3 treated as BCH8 |
| err_count | input | 4 | Number of valid locations |
| err_locs | input | 104 | Eight 13-bit locations; location k is in bits [13k+12:13k] |
| uncorrectable | input | 1 | Locator reports too many errors |
| parity_in | input | 208 | Stored parity bytes; byte k is in bits [8k+7:8k] |
| synd_in | input | 224 | Syndrome bytes, in read order |
| synd_out | output | 224 | Syndrome bytes, reversed for the locator |
| mem_addr | output | 9 | Buffer byte address |
| mem_rd_en | output | 1 | Buffer read strobe; data returns in the next cycle |
| mem_rdata | input | 8 | Buffer read data |
| mem_wr_en | output | 1 | Buffer write strobe |
| mem_wdata | output | 8 | Buffer write data |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| flip_count | output | 4 | Number of bits flipped in the last job |
| fail | output | 1 | Last job was aborted as uncorrectable |

## Verification
The bench aims at the edges of the parity span for each strength: the last parity index and the first data index. A design with an off-by-one in the span would either corrupt a byte or miss a correction. It also sends the first and last data bits, which a wrong bit reversal would place at the wrong end of the sector, and the first location past the sector, which a design without a range check would wrap onto a real byte. The bench further repeats a location, which a design that does not chain its read-modify-writes would leave flipped only once, and sends err_count above 8 and a start while busy. Parity that is 0xFF in all but one checked byte must still be corrected, and an unknown strength code must act as BCH8 rather than BCH4.

// File: rtl/bch_fix_pkg.sv
package bch_fix_pkg;

   typedef enum logic [2:0] {
      FX_IDLE  = 3'd0,
      FX_SCAN  = 3'd1,
      FX_READ  = 3'd2,
      FX_WRITE = 3'd3,
      FX_DONE  = 3'd4
   } fix_state_e;

   // code 3 folds onto the middle strength
   function automatic logic [1:0] norm_code(input logic [1:0] c);
      return (c == 2'd3) ? 2'd1 : c;
   endfunction

   function automatic int unsigned nibble_count(input logic [1:0] c);
      case (norm_code(c))
         2'd0:    return 13;
         2'd2:    return 52;
         default: return 26;
      endcase
   endfunction

   function automatic int unsigned parity_bit_count(input logic [1:0] c);
      return nibble_count(c) * 4;
   endfunction

   function automatic int unsigned parity_byte_count(input logic [1:0] c);
      return (nibble_count(c) + 1) / 2;
   endfunction

endpackage

// File: rtl/bch_loc_map.sv
module bch_loc_map
   import bch_fix_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int LOC_W        = 13,
   localparam int DATA_BITS   = SECTOR_BYTES * 8,
   localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
   input  logic [1:0]        strength,
   input  logic [LOC_W-1:0]  loc,
   output logic              hit,
   output logic [ADDR_W-1:0] byte_addr,
   output logic [2:0]        bit_sel
);

   generate
      if ((1 << LOC_W) < DATA_BITS + 208) begin : g_bad_w
         $error("LOC_W too narrow for sector plus parity");
      end
   endgenerate

   logic [LOC_W-1:0] span;
   logic [LOC_W-1:0] adj;

   always_comb begin
      span      = LOC_W'(parity_bit_count(strength));
      adj       = loc - span;
      hit       = (loc >= span) && (adj < LOC_W'(DATA_BITS));
      byte_addr = ADDR_W'((LOC_W'(DATA_BITS - 1) - adj) >> 3);
      bit_sel   = adj[2:0];
   end

endmodule

// File: rtl/bch_erase_detect.sv
module bch_erase_detect
   import bch_fix_pkg::*;
#(
   parameter int MAX_PAR = 26
) (
   input  logic [1:0]           strength,
   input  logic [MAX_PAR*8-1:0] parity_in,
   output logic                 erased
);

   generate
      if (MAX_PAR < 26) begin : g_bad_par
         $error("MAX_PAR must cover the largest parity field");
      end
   endgenerate

   logic [MAX_PAR-1:0] is_ff;

   generate
      for (genvar k = 0; k < MAX_PAR; k++) begin : g_cmp
         assign is_ff[k] = (parity_in[k*8 +: 8] == 8'hFF);
      end
   endgenerate

   always_comb begin
      erased = 1'b1;
      for (int k = 0; k < MAX_PAR; k++) begin
         if (k < int'(parity_byte_count(strength)) && !is_ff[k])
            erased = 1'b0;
      end
   end

endmodule

// File: rtl/bch_synd_reverse.sv
module bch_synd_reverse
   import bch_fix_pkg::*;
#(
   parameter int MAX_SYN = 28
) (
   input  logic [1:0]           strength,
   input  logic [MAX_SYN*8-1:0] synd_in,
   output logic [MAX_SYN*8-1:0] synd_out
);

   localparam int N4  = 8;
   localparam int N8  = 13;
   localparam int N16 = 28;

   generate
      if (MAX_SYN < N16) begin : g_bad_syn
         $error("MAX_SYN must cover the largest syndrome");
      end
   endgenerate

   logic [1:0] code;
   assign code = norm_code(strength);

   generate
      for (genvar i = 0; i < MAX_SYN; i++) begin : g_byte
         logic [7:0] b4, b8, b16;
         if (i < N4) begin : g_r4
            assign b4 = synd_in[(N4-1-i)*8 +: 8];
         end else begin : g_z4
            assign b4 = 8'h00;
         end
         if (i < N8) begin : g_r8
            assign b8 = synd_in[(N8-1-i)*8 +: 8];
         end else begin : g_z8
            assign b8 = 8'h00;
         end
         if (i < N16) begin : g_r16
            assign b16 = synd_in[(N16-1-i)*8 +: 8];
         end else begin : g_z16
            assign b16 = 8'h00;
         end
         assign synd_out[i*8 +: 8] = (code == 2'd0) ? b4 :
                                     (code == 2'd2) ? b16 : b8;
      end
   endgenerate

endmodule

// File: rtl/bch_bitfix.sv
module bch_bitfix
   import bch_fix_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int MAX_ERR      = 8,
   parameter int LOC_W        = 13,
   parameter int MAX_PAR      = 26,
   parameter int MAX_SYN      = 28,
   localparam int ADDR_W      = $clog2(SECTOR_BYTES),
   localparam int CNT_W       = $clog2(MAX_ERR + 1),
   localparam int IDX_W       = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [1:0]               strength,
   input  logic [CNT_W-1:0]         err_count,
   input  logic [MAX_ERR*LOC_W-1:0] err_locs,
   input  logic                     uncorrectable,
   input  logic [MAX_PAR*8-1:0]     parity_in,
   input  logic [MAX_SYN*8-1:0]     synd_in,
   output logic [MAX_SYN*8-1:0]     synd_out,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic                     mem_rd_en,
   input  logic [7:0]               mem_rdata,
   output logic                     mem_wr_en,
   output logic [7:0]               mem_wdata,
   output logic                     busy,
   output logic                     done,
   output logic [CNT_W-1:0]         flip_count,
   output logic                     fail
);

   generate
      if (MAX_ERR < 1) begin : g_bad_err
         $error("MAX_ERR must be at least 1");
      end
   endgenerate

   fix_state_e        state;
   logic [1:0]        strength_q;
   logic [LOC_W-1:0]  locs_q [MAX_ERR];
   logic [CNT_W-1:0]  lim_q;
   logic [CNT_W-1:0]  idx_q;
   logic [ADDR_W-1:0] tgt_addr;
   logic [7:0]        tgt_mask;
   logic [CNT_W-1:0]  flips_q;
   logic              fail_q;

   logic [LOC_W-1:0]  loc_cur;
   logic              map_hit;
   logic [ADDR_W-1:0] map_addr;
   logic [2:0]        map_bit;
   logic              sector_erased;
   logic [CNT_W-1:0]  lim_in;

   assign loc_cur = (idx_q < CNT_W'(MAX_ERR)) ? locs_q[idx_q[IDX_W-1:0]] : '0;
   assign lim_in  = (err_count > CNT_W'(MAX_ERR)) ? CNT_W'(MAX_ERR) : err_count;

   bch_loc_map #(.SECTOR_BYTES(SECTOR_BYTES), .LOC_W(LOC_W)) map_i (
      .strength (strength_q),
      .loc      (loc_cur),
      .hit      (map_hit),
      .byte_addr(map_addr),
      .bit_sel  (map_bit)
   );

   bch_erase_detect #(.MAX_PAR(MAX_PAR)) erase_i (
      .strength (strength),
      .parity_in(parity_in),
      .erased   (sector_erased)
   );

   bch_synd_reverse #(.MAX_SYN(MAX_SYN)) synd_i (
      .strength(strength),
      .synd_in (synd_in),
      .synd_out(synd_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= FX_IDLE;
         strength_q <= 2'd1;
         lim_q      <= '0;
         idx_q      <= '0;
         tgt_addr   <= '0;
         tgt_mask   <= 8'h00;
         flips_q    <= '0;
         fail_q     <= 1'b0;
         for (int k = 0; k < MAX_ERR; k++) locs_q[k] <= '0;
      end else begin
         case (state)
            FX_IDLE: begin
               if (start) begin
                  strength_q <= strength;
                  lim_q      <= lim_in;
                  idx_q      <= '0;
                  flips_q    <= '0;
                  fail_q     <= uncorrectable;
                  for (int k = 0; k < MAX_ERR; k++)
                     locs_q[k] <= err_locs[k*LOC_W +: LOC_W];
                  state <= (uncorrectable || sector_erased) ? FX_DONE : FX_SCAN;
               end
            end
            FX_SCAN: begin
               if (idx_q >= lim_q) begin
                  state <= FX_DONE;
               end else if (map_hit) begin
                  tgt_addr <= map_addr;
                  tgt_mask <= 8'h01 << map_bit;
                  state    <= FX_READ;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            FX_READ: state <= FX_WRITE;
            FX_WRITE: begin
               flips_q <= flips_q + 1'b1;
               idx_q   <= idx_q + 1'b1;
               state   <= FX_SCAN;
            end
            default: state <= FX_IDLE;
         endcase
      end
   end

   assign mem_addr   = tgt_addr;
   assign mem_rd_en  = (state == FX_READ);
   assign mem_wr_en  = (state == FX_WRITE);
   assign mem_wdata  = mem_rdata ^ tgt_mask;
   assign busy       = (state != FX_IDLE);
   assign done       = (state == FX_DONE);
   assign flip_count = flips_q;
   assign fail       = fail_q;

endmodule

// File: rtl/bch_bitfix_chk.sv
module bch_bitfix_chk #(
   parameter int MAX_ERR = 8,
   parameter int MAX_SYN = 28,
   parameter int ADDR_W  = 9,
   parameter int CNT_W   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [1:0]         strength,
   input logic               uncorrectable,
   input logic [MAX_SYN*8-1:0] synd_out,
   input logic [ADDR_W-1:0]  mem_addr,
   input logic               mem_rd_en,
   input logic [7:0]         mem_rdata,
   input logic               mem_wr_en,
   input logic [7:0]         mem_wdata,
   input logic               busy,
   input logic               done,
   input logic [CNT_W-1:0]   flip_count,
   input logic               fail
);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_rd_en && !mem_wr_en));

   p_single_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> ($countones(mem_wdata ^ mem_rdata) == 1));

   p_read_before_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> ($past(mem_rd_en) && ($past(mem_addr) == mem_addr)));

   p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd_en, mem_wr_en}));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && uncorrectable) |=> (done && fail && !mem_rd_en));

   p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flip_count <= CNT_W'(MAX_ERR));

   p_synd_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (strength == 2'd0) |-> (synd_out[MAX_SYN*8-1:64] == '0));

endmodule

bind bch_bitfix bch_bitfix_chk #(
   .MAX_ERR(MAX_ERR), .MAX_SYN(MAX_SYN), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) chk_i (.*);

// File: tb/bch_bitfix_tb_top.sv
`timescale 1ns/1ps
module bch_bitfix_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [1:0]   strength = 2'd1;
   logic [3:0]   err_count = '0;
   logic [103:0] err_locs = '0;
   logic         uncorrectable = 1'b0;
   logic [207:0] parity_in = '0;
   logic [223:0] synd_in = '0;
   logic [223:0] synd_out;
   logic [8:0]   mem_addr;
   logic         mem_rd_en;
   logic [7:0]   mem_rdata;
   logic         mem_wr_en;
   logic [7:0]   mem_wdata;
   logic         busy, done, fail;
   logic [3:0]   flip_count;

   always #2 clk = ~clk;

   bch_bitfix dut_i (.*);

   int checks = 0;
   int fails  = 0;
   logic [7:0] mem     [512];
   logic [7:0] exp_mem [512];
   logic [16:0] exp_q [$];

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_rdata <= 8'h00;
         for (int k = 0; k < 512; k++) mem[k] <= 8'(k * 7 + 3);
      end else begin
         if (mem_rd_en) mem_rdata <= mem[mem_addr];
         if (mem_wr_en) mem[mem_addr] <= mem_wdata;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // per-clock comparison of buffer traffic against the reference queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (!busy && (mem_rd_en || mem_wr_en))
            chk(0, "R1 access while idle", 1, 0);
         if (mem_wr_en) begin
            if (exp_q.size() == 0) begin
               chk(0, "R7 unexpected write", int'(mem_addr), -1);
            end else begin
               chk({mem_addr, mem_wdata} == exp_q[0], "R7 write addr/data",
                   int'({mem_addr, mem_wdata}), int'(exp_q[0]));
               void'(exp_q.pop_front());
            end
         end
      end
   end

   function automatic int nib(input logic [1:0] c);
      return (c == 2'd0) ? 13 : (c == 2'd2) ? 52 : 26;
   endfunction

   task automatic run_job(input logic [1:0] code, input int cnt, input int locs[8],
                          input bit unc, input bit poke, input string tag);
      int  span, nflip, waited, nb;
      bit  erased, seen;
      span = nib(code) * 4;
      nb = (nib(code) + 1) / 2;
      erased = 1;
      for (int k = 0; k < nb; k++) if (parity_in[k*8 +: 8] != 8'hFF) erased = 0;
      nflip = 0;
      if (!unc && !erased) begin
         for (int k = 0; k < ((cnt > 8) ? 8 : cnt); k++) begin
            int a = locs[k] - span;
            if (locs[k] >= span && a < 4096) begin
               int ba = (4095 - a) / 8;
               exp_mem[ba] = exp_mem[ba] ^ 8'(1 << (a % 8));
               exp_q.push_back({9'(ba), exp_mem[ba]});
               nflip++;
            end
         end
      end
      @(negedge clk);
      strength = code; err_count = 4'(cnt); uncorrectable = unc;
      for (int k = 0; k < 8; k++) err_locs[k*13 +: 13] = 13'(locs[k]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      seen = 0; waited = 0;
      while (!seen && waited < 200) begin
         if (done) seen = 1;
         else begin
            if (poke && waited == 2) begin
               start = 1'b1; err_count = 4'd0; uncorrectable = 1'b1;
            end else start = 1'b0;
            @(negedge clk);
            waited++;
         end
      end
      start = 1'b0; uncorrectable = 1'b0;
      chk(seen, {tag, " R9 done seen"}, int'(seen), 1);
      chk(flip_count == 4'(nflip), {tag, " R9 flip_count"}, int'(flip_count), nflip);
      chk(fail == unc, {tag, " R6 fail"}, int'(fail), int'(unc));
      @(negedge clk);
      chk(!done && !busy, {tag, " R9 done one cycle"}, int'(done), 0);
      chk(exp_q.size() == 0, {tag, " R7 writes missing"}, exp_q.size(), 0);
      begin
         int bad = 0;
         for (int k = 0; k < 512; k++) if (mem[k] !== exp_mem[k]) bad++;
         chk(bad == 0, {tag, " R3 sector contents"}, bad, 0);
      end
   endtask

   task automatic chk_synd(input logic [1:0] code, input int m, input string tag);
      @(negedge clk);
      strength = code;
      for (int i = 0; i < 28; i++) synd_in[i*8 +: 8] = 8'(i + 1);
      #1;
      begin
         int bad = 0;
         for (int i = 0; i < 28; i++) begin
            logic [7:0] e = (i < m) ? 8'(m - i) : 8'h00;
            if (synd_out[i*8 +: 8] !== e) bad++;
         end
         chk(bad == 0, tag, bad, 0);
      end
   endtask

   initial begin
      int L[8];
      for (int k = 0; k < 512; k++) exp_mem[k] = 8'(k * 7 + 3);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !fail && !mem_rd_en && !mem_wr_en && flip_count == 0,
          "R1 reset state", int'({busy, done, fail, mem_rd_en, mem_wr_en}), 0);

      // R2 R3 R4 BCH8: last parity, first/last data bit, just past sector
      L = '{103, 104, 4199, 4200, 1104, 0, 0, 0};
      run_job(2'd1, 5, L, 0, 0, "bch8 R2 R4");
      // R2 R7 BCH4 with repeated location
      L = '{51, 52, 300, 300, 4147, 0, 0, 0};
      run_job(2'd0, 5, L, 0, 0, "bch4 R7 repeat");
      // R2 R4 BCH16 edges
      L = '{207, 208, 2256, 4303, 4304, 0, 0, 0};
      run_job(2'd2, 5, L, 0, 0, "bch16 R2");
      // R11 code 3 acts as BCH8
      L = '{60, 110, 103, 0, 0, 0, 0, 0};
      run_job(2'd3, 3, L, 0, 0, "code3 R11");

      // R5 erased BCH8: 13 bytes 0xFF
      for (int k = 0; k < 13; k++) parity_in[k*8 +: 8] = 8'hFF;
      L = '{500, 600, 0, 0, 0, 0, 0, 0};
      run_job(2'd1, 2, L, 0, 0, "erased bch8 R5");
      run_job(2'd3, 2, L, 0, 0, "erased code3 R11");
      // R5 BCH16 needs 26 bytes: byte 25 not FF -> corrected
      for (int k = 13; k < 25; k++) parity_in[k*8 +: 8] = 8'hFF;
      run_job(2'd2, 1, L, 0, 0, "bch16 not erased R5");
      // R5 BCH4 one checked byte not FF
      parity_in = '0;
      for (int k = 0; k < 6; k++) parity_in[k*8 +: 8] = 8'hFF;
      parity_in[6*8 +: 8] = 8'hFE;
      run_job(2'd0, 1, L, 0, 0, "bch4 not erased R5");
      parity_in = '0;

      // R6 uncorrectable then cleared by next start
      run_job(2'd1, 2, L, 1, 0, "uncorr R6");
      run_job(2'd1, 1, L, 0, 0, "after uncorr R6");

      // R8 count clamp and zero count
      L = '{200, 300, 400, 500, 600, 700, 800, 900};
      run_job(2'd1, 12, L, 0, 0, "clamp R8");
      run_job(2'd1, 0, L, 0, 0, "zero R8");
      // R9 start while busy ignored
      L = '{1200, 1300, 1400, 1500, 0, 0, 0, 0};
      run_job(2'd1, 4, L, 0, 1, "poke R9");

      // R10 R11 syndrome reversal
      chk_synd(2'd0, 8,  "R10 reverse bch4");
      chk_synd(2'd1, 13, "R10 reverse bch8");
      chk_synd(2'd2, 28, "R10 reverse bch16");
      chk_synd(2'd3, 13, "R11 reverse code3");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule